// File: doc/BRIEF.md
# Orthogonal Latin Square Majority Decoder with Concurrent Error Detection

This block decodes one word of a binary orthogonal Latin square code per clock. The data word holds M*M bits laid out as an M by M array, and it travels with 2*T groups of M check bits. Each data bit is covered by exactly one check bit in every group. A syndrome is formed, and every data bit has its own majority voter over the 2*T syndrome bits that cover it. The voters flip up to T erroneous data bits in one pass. The default code has T = 2 and M = 3, which gives 9 data bits and 12 check bits. M must be a prime with M >= 2*T - 1.

The whole decoder is also checked for internal faults. The syndrome stage is guarded by comparing the parity of all check bits with the parity of all syndrome bits. The voters and the correction gates are guarded by comparing the parity of the corrected word with a prediction. The prediction is normally the majority of the per-group check parities. When exactly T groups have odd syndrome parity, it switches to the parity of the first check group XOR the parity of the first syndrome group. One rail of each equal-valued pair is inverted, and the two pairs are merged by a two-rail checker into (r1, r2). In a healthy decoder the two outputs differ; equal outputs mean a fault.

Setting PIPE_CHK places the prediction and the output parity tree one stage later. The corrected word then keeps its one-cycle latency, and its check result follows one cycle after it.

Top module: `ols_ced_dec`

## Requirements
- R1: Data bit index is r*M+col for array row r and column col. Check bit index is g*M+j. Check bit (g, j) is the XOR of the data bits selected as follows: for g = 0, those with r = j; for g = 1, those with col = j; for g >= 2, those with (col + (g-1)*r) mod M = j.
- R2: A received word with no error appears unchanged on v_out one clock after it is applied.
- R3: Any error of weight 1 to T confined to the data bits is corrected on v_out one clock later.
- R4: Any error of weight up to T confined to the check bits leaves v_out equal to the data bits.
- R5: Any mixed error on data and check bits with total weight up to T is corrected on v_out.
- R6: With no internal fault and any error of weight up to T, r1 differs from r2. The result for a word appears 1+PIPE_CHK clocks after the word is applied.
- R7: A voter output held at the wrong value, stuck at 1 or stuck at 0, makes r1 equal r2.
- R8: A correction XOR output held at the inverse of its correct value makes r1 equal r2.
- R9: After a clock with rst high, v_out is 0, r1 is 0 and r2 is 1.
- R10: Check-bit errors that make exactly T groups have odd syndrome parity give no fault indication and a correct v_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| u_in | input | M*M | Received data bits |
| c_in | input | 2*T*M | Received check bits |
| v_out | output | M*M | Registered corrected data word |
| r1 | output | 1 | Fault indication rail 1 (differs from r2 when healthy) |
| r2 | output | 1 | Fault indication rail 2 |

## Verification
Eight data words, including all zeros, all ones and alternating patterns, are combined with every error pattern of weight zero, one and two over all 21 code bits. Patterns confined to the data bits exercise the voters. Patterns confined to the check bits show that the data path ignores them and exercise the tie-break branch of the predictor. Mixed patterns exercise both at once. Stuck values are then forced onto each voter output, in both polarities, and onto each correction gate output. These runs separate a fault indication raised by the parity prediction from a silent miscorrection. Reset is applied both at start and in the middle of traffic.

// File: rtl/ols_pkg.sv
package ols_pkg;

  // Row index within group g of the check bit that covers data position pos.
  function automatic int grp_row(input int g, input int pos, input int m);
    int r;
    int cl;
    r  = pos / m;
    cl = pos % m;
    if (g == 0)      return r;
    else if (g == 1) return cl;
    else             return (cl + (g - 1) * r) % m;
  endfunction

endpackage

// File: rtl/ols_syndrome.sv
module ols_syndrome
  import ols_pkg::*;
#(
  parameter int T = 2,
  parameter int M = 3
) (
  input  logic [M*M-1:0]   u,
  input  logic [2*T*M-1:0] c,
  output logic [2*T*M-1:0] syn,
  output logic [2*T-1:0]   cpar,
  output logic [2*T-1:0]   spar
);
  localparam int K = M * M;
  localparam int G = 2 * T;

  for (genvar g = 0; g < G; g++) begin : g_grp
    for (genvar j = 0; j < M; j++) begin : g_bit
      logic acc;
      always_comb begin
        acc = c[g*M+j];
        for (int pos = 0; pos < K; pos++) begin
          if (grp_row(g, pos, M) == j) acc = acc ^ u[pos];
        end
      end
      assign syn[g*M+j] = acc;
    end
    assign cpar[g] = ^c[g*M +: M];
    assign spar[g] = ^syn[g*M +: M];
  end

endmodule

// File: rtl/ols_voter.sv
module ols_voter
  import ols_pkg::*;
#(
  parameter int T = 2,
  parameter int M = 3
) (
  input  logic [2*T*M-1:0] syn,
  output logic [M*M-1:0]   err
);
  localparam int K = M * M;
  localparam int G = 2 * T;

  // One independent voter per data bit; no logic is shared between voters.
  for (genvar pos = 0; pos < K; pos++) begin : g_vote
    logic [G-1:0] votes;
    for (genvar g = 0; g < G; g++) begin : g_tap
      assign votes[g] = syn[g*M + grp_row(g, pos, M)];
    end
    assign err[pos] = ($countones(votes) > T);
  end

endmodule

// File: rtl/ols_pred.sv
module ols_pred #(
  parameter int T = 2
) (
  input  logic [2*T-1:0] cpar,
  input  logic [2*T-1:0] spar,
  output logic           roth1
);
  int  n_syn;
  int  n_chk;
  logic tie;
  logic maj;

  always_comb begin
    n_syn = $countones(spar);
    n_chk = $countones(cpar);
    tie   = (n_syn == T);
    maj   = (n_chk > T);
    roth1 = tie ? (cpar[0] ^ spar[0]) : maj;
  end

endmodule

// File: rtl/ols_two_rail.sv
module ols_two_rail (
  input  logic a0,
  input  logic a1,
  input  logic b0,
  input  logic b1,
  output logic z0,
  output logic z1
);
  assign z0 = (a0 & b0) | (a1 & b1);
  assign z1 = (a0 & b1) | (a1 & b0);
endmodule

// File: rtl/ols_ced_dec.sv
module ols_ced_dec #(
  parameter int T        = 2,
  parameter int M        = 3,
  parameter bit PIPE_CHK = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [M*M-1:0]   u_in,
  input  logic [2*T*M-1:0] c_in,
  output logic [M*M-1:0]   v_out,
  output logic             r1,
  output logic             r2
);
  localparam int K  = M * M;
  localparam int G  = 2 * T;
  localparam int NC = G * M;

  logic [NC-1:0] syn;
  logic [G-1:0]  cpar;
  logic [G-1:0]  spar;
  logic [K-1:0]  err_pat;
  logic [K-1:0]  v_raw;

  ols_syndrome #(.T(T), .M(M)) u_syn (
    .u(u_in), .c(c_in), .syn(syn), .cpar(cpar), .spar(spar)
  );

  ols_voter #(.T(T), .M(M)) u_vote (
    .syn(syn), .err(err_pat)
  );

  assign v_raw = u_in ^ err_pat;

  always_ff @(posedge clk) begin
    if (rst) v_out <= '0;
    else     v_out <= v_raw;
  end

  // Signals feeding the parity prediction and the output parity tree.
  logic [G-1:0] cp_s;
  logic [G-1:0] sp_s;
  logic [K-1:0] vv_s;

  if (PIPE_CHK) begin : g_pipe
    logic [G-1:0] cpar_q;
    logic [G-1:0] spar_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cpar_q <= '0;
        spar_q <= '0;
      end else begin
        cpar_q <= cpar;
        spar_q <= spar;
      end
    end
    assign cp_s = cpar_q;
    assign sp_s = spar_q;
    assign vv_s = v_out;
  end else begin : g_flat
    assign cp_s = cpar;
    assign sp_s = spar;
    assign vv_s = v_raw;
  end

  logic rsyn1;
  logic rsyn2;
  logic roth1;
  logic roth2;
  logic z0;
  logic z1;

  assign rsyn1 = ^cp_s;
  assign rsyn2 = ^sp_s;
  assign roth2 = ^vv_s;

  ols_pred #(.T(T)) u_pred (
    .cpar(cp_s), .spar(sp_s), .roth1(roth1)
  );

  ols_two_rail u_merge (
    .a0(rsyn1), .a1(~rsyn2), .b0(roth1), .b1(~roth2), .z0(z0), .z1(z1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      r1 <= 1'b0;
      r2 <= 1'b1;
    end else begin
      r1 <= z0;
      r2 <= z1;
    end
  end

endmodule

// File: rtl/ols_ced_dec_chk.sv
module ols_ced_dec_chk
  import ols_pkg::*;
#(
  parameter int T        = 2,
  parameter int M        = 3,
  parameter bit PIPE_CHK = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [M*M-1:0]   u_in,
  input logic [2*T*M-1:0] c_in,
  input logic [M*M-1:0]   v_out,
  input logic             r1,
  input logic             r2
);
  localparam int K  = M * M;
  localparam int G  = 2 * T;
  localparam int NC = G * M;

  function automatic logic [NC-1:0] encode(input logic [K-1:0] d);
    logic [NC-1:0] cw;
    cw = '0;
    for (int g = 0; g < G; g++)
      for (int p = 0; p < K; p++)
        cw[g*M + grp_row(g, p, M)] ^= d[p];
    return cw;
  endfunction

  int w;
  logic [2:0] kind;  // [0] clean, [1] single check-bit error, [2] single data-bit error
  always_comb begin
    w    = $countones(c_in ^ encode(u_in));
    kind = {w == G, w == 1, w == 0};
  end

  logic [K-1:0] u_d [0:PIPE_CHK];
  logic [2:0]   k_d [0:PIPE_CHK];
  logic [K-1:0] v_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= PIPE_CHK; i++) begin
        u_d[i] <= '0;
        k_d[i] <= '0;
      end
      v_d <= '0;
    end else begin
      u_d[0] <= u_in;
      k_d[0] <= kind;
      for (int i = 1; i <= PIPE_CHK; i++) begin
        u_d[i] <= u_d[i-1];
        k_d[i] <= k_d[i-1];
      end
      v_d <= v_out;
    end
  end

  logic [K-1:0] u_al;
  logic [2:0]   k_al;
  logic [K-1:0] v_al;
  assign u_al = u_d[PIPE_CHK];
  assign k_al = k_d[PIPE_CHK];
  assign v_al = PIPE_CHK ? v_d : v_out;

  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (v_out == '0) && !r1 && r2);

  a_r2_clean_secure: assert property (@(posedge clk) disable iff (rst)
    (k_al[0] && (v_al != u_al)) |-> (r1 == r2));

  a_r4_chk_err_secure: assert property (@(posedge clk) disable iff (rst)
    (k_al[1] && (v_al != u_al)) |-> (r1 == r2));

  a_r3_data_err_secure: assert property (@(posedge clk) disable iff (rst)
    (k_al[2] && ($countones(v_al ^ u_al) != 1)) |-> (r1 == r2));

endmodule

bind ols_ced_dec ols_ced_dec_chk #(.T(T), .M(M), .PIPE_CHK(PIPE_CHK)) u_chk (
  .clk(clk), .rst(rst), .u_in(u_in), .c_in(c_in),
  .v_out(v_out), .r1(r1), .r2(r2)
);

// File: tb/ols_ced_dec_test.sv
module ols_ced_dec_test;
  localparam int CLK_PERIOD = 10;
  localparam int T  = 2;
  localparam int M  = 3;
  localparam int K  = M * M;
  localparam int G  = 2 * T;
  localparam int NC = G * M;
  localparam int NB = K + NC;

  localparam logic [K-1:0] DATA_TAB [8] = '{
    9'h000, 9'h1FF, 9'h155, 9'h0AA, 9'h001, 9'h100, 9'h0F3, 9'h12C
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [K-1:0]  u_in = '0;
  logic [NC-1:0] c_in = '0;
  logic [K-1:0]  v_out;
  logic r1, r2;
  logic [K-1:0] fault_val = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ols_ced_dec #(.T(T), .M(M), .PIPE_CHK(1'b1)) uut (
    .clk(clk), .rst(rst), .u_in(u_in), .c_in(c_in),
    .v_out(v_out), .r1(r1), .r2(r2)
  );

  // Encoder written from R1.
  function automatic logic [NC-1:0] enc(input logic [K-1:0] d);
    logic [NC-1:0] cw;
    int row;
    cw = '0;
    for (int g = 0; g < G; g++)
      for (int r = 0; r < M; r++)
        for (int cl = 0; cl < M; cl++) begin
          if (g == 0)      row = r;
          else if (g == 1) row = cl;
          else             row = (cl + (g - 1) * r) % M;
          cw[g*M + row] ^= d[r*M + cl];
        end
    return cw;
  endfunction

  task automatic chk(input string tag, input logic [K-1:0] act, input logic [K-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [K-1:0] uu, input logic [NC-1:0] cc);
    @(negedge clk);
    u_in = uu;
    c_in = cc;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [K-1:0] flag();
    return {{(K-1){1'b0}}, (r1 === r2)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] cw;
    logic [NB-1:0] e;
    logic [NB-1:0] rx;
    string tag;

    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 v_out in reset", v_out, '0);
    chk("R9 rails in reset", {{(K-2){1'b0}}, r1, r2}, 9'b01);
    rst = 1'b0;

    // Exhaustive correctable patterns on a table of data words.
    for (int di = 0; di < 8; di++) begin
      cw = {enc(DATA_TAB[di]), DATA_TAB[di]};
      for (int a = 0; a <= NB; a++) begin
        for (int b = a; b <= NB; b++) begin
          if (a == b && a != NB) continue;
          e = '0;
          if (a < NB) e[a] = 1'b1;
          if (b < NB) e[b] = 1'b1;
          rx = cw ^ e;
          run_vec(rx[K-1:0], rx[NB-1:K]);
          if (e == '0)                tag = "R2 clean word";
          else if (e[NB-1:K] == '0)   tag = "R3 data error (R1 layout)";
          else if (e[K-1:0] == '0)    tag = "R4 check-bit error";
          else                        tag = "R5 mixed error";
          chk(tag, v_out, DATA_TAB[di]);
          chk("R6 no fault flag", flag(), '0);
        end
      end
    end

    // R10: check errors in groups 0 and 1 give exactly T odd syndrome groups.
    run_vec(9'h0F3, enc(9'h0F3) ^ 12'h009);
    chk("R10 tie case v_out", v_out, 9'h0F3);
    chk("R10 tie case flag", flag(), '0);

    // R7: voter outputs stuck at 1 on a clean word.
    for (int j = 0; j < K; j++) begin
      @(negedge clk);
      u_in = 9'h155;
      c_in = enc(9'h155);
      fault_val = '0;
      fault_val[j] = 1'b1;
      force uut.err_pat = fault_val;
      @(negedge clk);
      @(negedge clk);
      chk("R7 voter stuck-at-1 flag", flag(), 9'h001);
      release uut.err_pat;
    end

    // R7: voter output stuck at 0 while a single data error is present.
    for (int j = 0; j < K; j++) begin
      @(negedge clk);
      u_in = 9'h0AA ^ (9'h001 << j);
      c_in = enc(9'h0AA);
      fault_val = '0;
      force uut.err_pat = fault_val;
      @(negedge clk);
      @(negedge clk);
      chk("R7 voter stuck-at-0 flag", flag(), 9'h001);
      release uut.err_pat;
    end

    // R8: correction XOR output inverted.
    for (int j = 0; j < K; j++) begin
      @(negedge clk);
      u_in = 9'h12C;
      c_in = enc(9'h12C);
      fault_val = 9'h12C ^ (9'h001 << j);
      force uut.v_raw = fault_val;
      @(negedge clk);
      @(negedge clk);
      chk("R8 correction gate fault flag", flag(), 9'h001);
      release uut.v_raw;
    end

    // Recovery after the faults are removed.
    run_vec(9'h1FF, enc(9'h1FF));
    chk("R2 word after fault release", v_out, 9'h1FF);
    chk("R6 flag after fault release", flag(), '0);

    // R9: reset in the middle of traffic.
    run_vec(9'h155, enc(9'h155) ^ 12'h001);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 v_out after mid-run reset", v_out, '0);
    chk("R9 rails after mid-run reset", {{(K-2){1'b0}}, r1, r2}, 9'b01);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule